// File: doc/BRIEF.md
# Repeat Prefix String Sequencer

This block sits behind an instruction prefetch queue and takes one byte per cycle from it. It sorts each byte into one of five classes: repeat prefix, segment prefix, string opcode, opcode with one immediate byte, or one-byte opcode. A repeat prefix sets a hidden decoder bit. Only a string opcode looks at that bit; every other instruction runs once and the bit is simply dropped. A string opcode with the bit set starts a loop. The loop issues one execute strobe per iteration and one decrement strobe to an external count register, and it ends when that register reaches zero.

The block also decides where single-step traps and interrupts may be taken. A prefix and the opcode it modifies are never split. Once an instruction has completed, an acknowledge is raised that carries the address of the next instruction. Between two iterations of a repeated string operation an acknowledge is also allowed, and it carries the address of the most recent prefix byte. A re-fetch from that address decodes the repeat again. Any prefix that came before it is lost.

Top module: `strop_sequencer`

## Requirements
- R1: `qs_o` is 01 in every cycle in which a prefix or opcode byte is consumed. It is 11 when the immediate byte of an instruction is consumed. It is 00 in every other cycle, including all cycles of a repeat loop, even when `byte_vld_i` is high.
- R2: Bytes are classified as follows:
  - F2 and F3 are repeat prefixes.
  - 26, 2E, 36 and 3E are segment prefixes.
  - A4 to A7 and AA to AF are string opcodes.
  - B0 to BF are opcodes followed by one immediate byte.
  - Every other byte is a one-byte opcode.
- R3: A non-string opcode that follows a repeat prefix completes once. It raises `done_o` for one cycle with no `exec_o` and no `cnt_dec_o`, and the repeat bit is cleared afterwards.
- R4: A string opcode with the repeat bit set enters a loop. In the cycle after the opcode, and in each cycle after that, the loop raises `exec_o` and `cnt_dec_o` while `count_i` is nonzero. `done_o` is raised together with the iteration that sees `count_i` equal to 1.
- R5: If `count_i` is 0 in the first loop cycle, `done_o` is raised with no `exec_o` and no `cnt_dec_o`.
- R6: A string opcode without the repeat bit raises `exec_o` and `done_o` in the cycle it is consumed. It never raises `cnt_dec_o`, so the count is left unchanged.
- R7: No acknowledge is raised in a cycle that consumes a prefix byte, whatever the values of `step_i` and `irq_i`.
- R8: When `done_o` is high and `step_i` or `irq_i` is high, `ack_o` is raised in the same cycle. `resume_addr_o` then equals the address of the last byte of the instruction plus one.
- R9: During a loop iteration that leaves a nonzero count, `ack_o` is raised if `step_i` or `irq_i` is high. In that case `done_o` stays low, `resume_addr_o` equals the address of the last prefix byte, the loop stops, and the repeat bit is cleared.
- R10: Only the address of the last prefix before the string opcode is kept for the resume address. For a segment prefix followed by a repeat prefix it is the repeat prefix's address; for the opposite order it is the segment prefix's address.
- R11: `ack_irq_o` equals `irq_i` whenever `ack_o` is high.
- R12: While reset is held and no byte is offered, all outputs are low. Reset clears the repeat bit, so a string opcode right after reset runs a single iteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | Prefetch queue offers a byte |
| byte_i | input | 8 | Offered byte |
| byte_addr_i | input | AW | Address of the offered byte |
| count_i | input | CW | Current value of the count register |
| irq_i | input | 1 | Interrupt request |
| step_i | input | 1 | Single-step flag |
| qs_o | output | 2 | Queue status code |
| exec_o | output | 1 | One string iteration executes |
| cnt_dec_o | output | 1 | Decrement the count register |
| done_o | output | 1 | Instruction completes |
| ack_o | output | 1 | Trap or interrupt taken |
| ack_irq_o | output | 1 | The acknowledge is for an interrupt |
| resume_addr_o | output | AW | Address at which execution resumes |

## Verification
The hardest case to reach is an acknowledge in the middle of a loop. It needs several prefixes in a chosen order, a count large enough that the loop survives past its first iteration, and an interrupt or step request raised exactly on an iteration that leaves a nonzero count. The bench keeps its own model of the count register, which it loads and decrements from `cnt_dec_o`. It raises `irq_i` or `step_i` only on the chosen loop cycle. It then re-feeds the bytes from the reported resume address and checks that the remaining count is consumed. The bench also holds `byte_vld_i` high during loops to show that no byte is taken.

// File: rtl/strop_pkg.sv
package strop_pkg;
  typedef enum logic [2:0] {
    BC_OTHER = 3'd0,
    BC_IMM   = 3'd1,
    BC_STR   = 3'd2,
    BC_REP   = 3'd3,
    BC_SEG   = 3'd4
  } byte_class_e;

  typedef enum logic [1:0] {
    QS_NONE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_NEXT  = 2'b11
  } qstat_e;

  typedef enum logic [1:0] {
    ST_OPC  = 2'd0,
    ST_IMM  = 2'd1,
    ST_LOOP = 2'd2
  } seq_state_e;

  localparam int unsigned NUM_SEG = 4;
endpackage

// File: rtl/strop_classify.sv
module strop_classify
  import strop_pkg::*;
(
  input  logic [7:0]  byte_i,
  output byte_class_e cls_o
);
  logic [NUM_SEG-1:0] seg_hit;

  // segment prefixes are 26 + 8*n
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    assign seg_hit[g] = (byte_i == (8'h26 | 8'(g << 3)));
  end

  logic is_rep, is_str, is_imm;
  assign is_rep = (byte_i[7:1] == 7'h79);
  assign is_str = (byte_i[7:4] == 4'hA) && (byte_i[2] || (byte_i[3] && byte_i[1]));
  assign is_imm = (byte_i[7:4] == 4'hB);

  always_comb begin
    if (is_rep)          cls_o = BC_REP;
    else if (|seg_hit)   cls_o = BC_SEG;
    else if (is_str)     cls_o = BC_STR;
    else if (is_imm)     cls_o = BC_IMM;
    else                 cls_o = BC_OTHER;
  end
endmodule

// File: rtl/strop_prefix_state.sv
module strop_prefix_state #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_rep_i,
  input  logic          set_pfx_i,
  input  logic          clr_i,
  input  logic [AW-1:0] addr_i,
  output logic          rep_o,
  output logic [AW-1:0] pfx_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_o      <= 1'b0;
      pfx_addr_o <= '0;
    end else begin
      if (clr_i)          rep_o <= 1'b0;
      else if (set_rep_i) rep_o <= 1'b1;
      if (set_pfx_i)      pfx_addr_o <= addr_i;
    end
  end

  assert_rep_cleared_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !rep_o);
  assert_last_prefix_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_pfx_i |=> (pfx_addr_o == $past(addr_i)));
endmodule

// File: rtl/strop_ctrl.sv
module strop_ctrl
  import strop_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_vld_i,
  input  byte_class_e   cls_i,
  input  logic [AW-1:0] byte_addr_i,
  input  logic [CW-1:0] count_i,
  input  logic          rep_i,
  input  logic          evt_i,
  output qstat_e        qs_o,
  output logic          exec_o,
  output logic          cnt_dec_o,
  output logic          done_o,
  output logic          mid_o,
  output logic          set_rep_o,
  output logic          set_pfx_o,
  output logic          clr_o,
  output logic [AW-1:0] next_addr_o
);
  seq_state_e    st_q, st_d;
  logic [AW-1:0] nxt_q, nxt_d;
  logic          cnt_zero, cnt_last;

  assign cnt_zero = (count_i == '0);
  assign cnt_last = (count_i == CW'(1));

  always_comb begin
    st_d        = st_q;
    nxt_d       = nxt_q;
    qs_o        = QS_NONE;
    exec_o      = 1'b0;
    cnt_dec_o   = 1'b0;
    done_o      = 1'b0;
    mid_o       = 1'b0;
    set_rep_o   = 1'b0;
    set_pfx_o   = 1'b0;
    next_addr_o = byte_addr_i + AW'(1);
    unique case (st_q)
      ST_OPC: if (byte_vld_i) begin
        qs_o = QS_FIRST;
        unique case (cls_i)
          BC_REP: begin set_rep_o = 1'b1; set_pfx_o = 1'b1; end
          BC_SEG: set_pfx_o = 1'b1;
          BC_STR: begin
            if (rep_i) begin
              st_d  = ST_LOOP;
              nxt_d = byte_addr_i + AW'(1);
            end else begin
              exec_o = 1'b1;
              done_o = 1'b1;
            end
          end
          BC_IMM:  st_d = ST_IMM;
          default: done_o = 1'b1;
        endcase
      end
      ST_IMM: if (byte_vld_i) begin
        qs_o   = QS_NEXT;
        done_o = 1'b1;
        st_d   = ST_OPC;
      end
      ST_LOOP: begin
        next_addr_o = nxt_q;
        if (cnt_zero) begin
          done_o = 1'b1;
          st_d   = ST_OPC;
        end else begin
          exec_o    = 1'b1;
          cnt_dec_o = 1'b1;
          if (cnt_last) begin
            done_o = 1'b1;
            st_d   = ST_OPC;
          end else begin
            mid_o = 1'b1;
            if (evt_i) st_d = ST_OPC;
          end
        end
      end
      default: st_d = ST_OPC;
    endcase
  end

  assign clr_o = done_o || (mid_o && evt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_OPC;
      nxt_q <= '0;
    end else begin
      st_q  <= st_d;
      nxt_q <= nxt_d;
    end
  end

  assert_qs_needs_byte_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qs_o != QS_NONE) |-> byte_vld_i);
  assert_dec_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_dec_o |-> !cnt_zero);
  assert_plain_no_dec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && !rep_i) |-> !cnt_dec_o);
  assert_loop_continues_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mid_o && !evt_i) |=> (qs_o == QS_NONE));
endmodule

// File: rtl/strop_boundary.sv
module strop_boundary #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic          mid_i,
  input  logic          step_i,
  input  logic          irq_i,
  input  logic [AW-1:0] next_addr_i,
  input  logic [AW-1:0] pfx_addr_i,
  output logic          ack_o,
  output logic          ack_irq_o,
  output logic [AW-1:0] resume_addr_o
);
  logic evt;
  assign evt           = step_i || irq_i;
  assign ack_o         = (done_i || mid_i) && evt;
  assign ack_irq_o     = ack_o && irq_i;
  // mid-loop resumes at the prefix so the repeat is decoded again
  assign resume_addr_o = mid_i ? pfx_addr_i : next_addr_i;

  assert_ack_at_boundary_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (done_i || mid_i));
  assert_mid_not_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_i |-> !done_i);
endmodule

// File: rtl/strop_sequencer.sv
module strop_sequencer
  import strop_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_vld_i,
  input  logic [7:0]    byte_i,
  input  logic [AW-1:0] byte_addr_i,
  input  logic [CW-1:0] count_i,
  input  logic          irq_i,
  input  logic          step_i,
  output logic [1:0]    qs_o,
  output logic          exec_o,
  output logic          cnt_dec_o,
  output logic          done_o,
  output logic          ack_o,
  output logic          ack_irq_o,
  output logic [AW-1:0] resume_addr_o
);
  byte_class_e   cls;
  qstat_e        qs;
  logic          rep, mid, set_rep, set_pfx, clr;
  logic [AW-1:0] pfx_addr, next_addr;

  strop_classify i_classify (.byte_i(byte_i), .cls_o(cls));

  strop_prefix_state #(.AW(AW)) i_prefix (
    .clk_i, .rst_ni,
    .set_rep_i (set_rep),
    .set_pfx_i (set_pfx),
    .clr_i     (clr),
    .addr_i    (byte_addr_i),
    .rep_o     (rep),
    .pfx_addr_o(pfx_addr)
  );

  strop_ctrl #(.AW(AW), .CW(CW)) i_ctrl (
    .clk_i, .rst_ni,
    .byte_vld_i, .cls_i(cls), .byte_addr_i, .count_i,
    .rep_i      (rep),
    .evt_i      (step_i || irq_i),
    .qs_o       (qs),
    .exec_o, .cnt_dec_o, .done_o,
    .mid_o      (mid),
    .set_rep_o  (set_rep),
    .set_pfx_o  (set_pfx),
    .clr_o      (clr),
    .next_addr_o(next_addr)
  );

  strop_boundary #(.AW(AW)) i_boundary (
    .clk_i, .rst_ni,
    .done_i(done_o), .mid_i(mid), .step_i, .irq_i,
    .next_addr_i(next_addr), .pfx_addr_i(pfx_addr),
    .ack_o, .ack_irq_o, .resume_addr_o
  );

  assign qs_o = qs;

  assert_no_ack_on_prefix_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((qs == QS_FIRST) && (cls == BC_REP || cls == BC_SEG)) |-> !ack_o);
  assert_irq_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (ack_irq_o == irq_i));
endmodule

// File: tb/test_strop_sequencer.sv
module test_strop_sequencer;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam logic [1:0] Q0 = 2'b00, Q1 = 2'b01, Q3 = 2'b11;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic byte_vld = 1'b0, irq = 1'b0, stp = 1'b0;
  logic [7:0] byte_v = '0;
  logic [AW-1:0] addr = '0;
  logic [CW-1:0] cnt = '0, ld_val = '0;
  logic ld = 1'b0;
  logic [1:0] qs;
  logic exec, dec, done, ack, ack_irq;
  logic [AW-1:0] res;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  strop_sequencer #(.AW(AW), .CW(CW)) i_strop_sequencer (
    .clk_i(clk), .rst_ni, .byte_vld_i(byte_vld), .byte_i(byte_v), .byte_addr_i(addr),
    .count_i(cnt), .irq_i(irq), .step_i(stp), .qs_o(qs), .exec_o(exec),
    .cnt_dec_o(dec), .done_o(done), .ack_o(ack), .ack_irq_o(ack_irq), .resume_addr_o(res)
  );

  // count register model
  always @(posedge clk) begin
    if (ld) cnt <= ld_val;
    else if (dec) cnt <= cnt - 1'b1;
  end

  typedef struct {
    logic [1:0] qs; logic ex, dc, dn, ak, ai; logic [AW-1:0] rs; string tag;
  } exp_t;
  exp_t exp_q[$];

  // monitor
  always @(negedge clk) begin
    #8;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (qs !== e.qs || exec !== e.ex || dec !== e.dc || done !== e.dn || ack !== e.ak ||
          (e.ak && (ack_irq !== e.ai || res !== e.rs))) begin
        errors++;
        $display("FAIL %s: got qs=%b ex=%b dc=%b dn=%b ak=%b ai=%b rs=%h exp qs=%b ex=%b dc=%b dn=%b ak=%b ai=%b rs=%h",
                 e.tag, qs, exec, dec, done, ack, ack_irq, res,
                 e.qs, e.ex, e.dc, e.dn, e.ak, e.ai, e.rs);
      end
    end
  end

  task automatic cyc(input logic v, input logic [7:0] b, input logic [AW-1:0] a,
                     input logic i, input logic s, input logic [1:0] eqs,
                     input logic eex, input logic edc, input logic edn, input logic eak,
                     input logic eai, input logic [AW-1:0] ers, input string tag);
    exp_t e;
    @(negedge clk);
    byte_vld = v; byte_v = b; addr = a; irq = i; stp = s;
    e.qs = eqs; e.ex = eex; e.dc = edc; e.dn = edn; e.ak = eak; e.ai = eai; e.rs = ers;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    cyc(0, 8'h00, '0, 0, 0, Q0, 0, 0, 0, 0, 0, '0, tag);
  endtask

  task automatic set_count(input logic [CW-1:0] v);
    ld_val = v; ld = 1'b1;
    idle("R12 idle");
    ld = 1'b0;
  endtask

  task automatic chk_cnt(input logic [CW-1:0] v, input string tag);
    idle(tag);
    #1;
    checks++;
    if (cnt !== v) begin
      errors++;
      $display("FAIL %s count: got %0d exp %0d", tag, cnt, v);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got hang exp finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R12: outputs low during reset
    #15;
    checks++;
    if ({qs, exec, dec, done, ack} !== 6'b0) begin
      errors++;
      $display("FAIL R12 reset outputs: got %b exp 0", {qs, exec, dec, done, ack});
    end
    @(negedge clk); rst_ni = 1'b1;
    idle("R12 after reset");

    // R1/R2: one-byte and immediate opcodes
    cyc(1, 8'h90, 16'h0100, 0, 0, Q1, 0, 0, 1, 0, 0, '0, "R1 R2 one-byte op");
    cyc(1, 8'hB4, 16'h0101, 0, 0, Q1, 0, 0, 0, 0, 0, '0, "R1 R2 imm opcode");
    cyc(1, 8'h34, 16'h0102, 0, 0, Q3, 0, 0, 1, 0, 0, '0, "R1 imm byte");
    idle("R1 idle");

    // R3: repeat before non-string, then plain string runs once (R6)
    set_count(16'd5);
    cyc(1, 8'hF3, 16'h0110, 0, 0, Q1, 0, 0, 0, 0, 0, '0, "R3 rep prefix");
    cyc(1, 8'h90, 16'h0111, 0, 0, Q1, 0, 0, 1, 0, 0, '0, "R3 non-string once");
    cyc(1, 8'hA4, 16'h0112, 0, 0, Q1, 1, 0, 1, 0, 0, '0, "R3 R6 plain string");
    chk_cnt(16'd5, "R6");

    // R4: repeated loop of 3, queue byte offered but not taken
    set_count(16'd3);
    cyc(1, 8'hF3, 16'h0120, 0, 0, Q1, 0, 0, 0, 0, 0, '0, "R4 rep");
    cyc(1, 8'hA5, 16'h0121, 0, 0, Q1, 0, 0, 0, 0, 0, '0, "R4 string opcode");
    cyc(1, 8'h90, 16'h0122, 0, 0, Q0, 1, 1, 0, 0, 0, '0, "R4 R1 iter 3");
    cyc(1, 8'h90, 16'h0122, 0, 0, Q0, 1, 1, 0, 0, 0, '0, "R4 R1 iter 2");
    cyc(1, 8'h90, 16'h0122, 0, 0, Q0, 1, 1, 1, 0, 0, '0, "R4 iter 1 done");
    chk_cnt(16'd0, "R4");

    // R5: zero count
    cyc(1, 8'hF2, 16'h0130, 0, 0, Q1, 0, 0, 0, 0, 0, '0, "R5 rep");
    cyc(1, 8'hAA, 16'h0131, 0, 0, Q1, 0, 0, 0, 0, 0, '0, "R5 string opcode");
    cyc(0, 8'h00, 16'h0000, 0, 0, Q0, 0, 0, 1, 0, 0, '0, "R5 zero iterations");
    chk_cnt(16'd0, "R5");

    // R7/R8: step over prefix, trap after instruction
    cyc(1, 8'hF3, 16'h0140, 1, 1, Q1, 0, 0, 0, 0, 0, '0, "R7 prefix with step+irq");
    cyc(1, 8'h90, 16'h0141, 0, 1, Q1, 0, 0, 1, 1, 0, 16'h0142, "R8 step trap");
    // R8/R11: interrupt at immediate instruction end
    cyc(1, 8'hB0, 16'h0150, 1, 0, Q1, 0, 0, 0, 0, 0, '0, "R8 no ack mid-instruction");
    cyc(1, 8'h11, 16'h0151, 1, 0, Q3, 0, 0, 1, 1, 1, 16'h0152, "R8 R11 irq ack");
    idle("R8 idle");

    // R9/R10: seg then rep, irq mid-loop, resume at rep
    set_count(16'd4);
    cyc(1, 8'h2E, 16'h0160, 0, 0, Q1, 0, 0, 0, 0, 0, '0, "R2 seg prefix");
    cyc(1, 8'hF3, 16'h0161, 0, 0, Q1, 0, 0, 0, 0, 0, '0, "R10 rep");
    cyc(1, 8'hA4, 16'h0162, 0, 0, Q1, 0, 0, 0, 0, 0, '0, "R10 string");
    cyc(0, 8'h00, 16'h0000, 0, 0, Q0, 1, 1, 0, 0, 0, '0, "R9 iter");
    cyc(0, 8'h00, 16'h0000, 1, 0, Q0, 1, 1, 0, 1, 1, 16'h0161, "R9 R10 R11 mid irq");
    chk_cnt(16'd2, "R9");
    cyc(1, 8'hF3, 16'h0161, 0, 0, Q1, 0, 0, 0, 0, 0, '0, "R9 resume rep");
    cyc(1, 8'hA4, 16'h0162, 0, 0, Q1, 0, 0, 0, 0, 0, '0, "R9 resume string");
    cyc(0, 8'h00, 16'h0000, 0, 0, Q0, 1, 1, 0, 0, 0, '0, "R9 iter 2");
    cyc(0, 8'h00, 16'h0000, 0, 0, Q0, 1, 1, 1, 0, 0, '0, "R9 iter 1");
    chk_cnt(16'd0, "R9 end");

    // R10: rep then seg, step mid-loop resumes at seg; repeat bit cleared (R9)
    set_count(16'd3);
    cyc(1, 8'hF3, 16'h0170, 0, 0, Q1, 0, 0, 0, 0, 0, '0, "R10 rep");
    cyc(1, 8'h3E, 16'h0171, 0, 0, Q1, 0, 0, 0, 0, 0, '0, "R10 seg");
    cyc(1, 8'hA6, 16'h0172, 0, 0, Q1, 0, 0, 0, 0, 0, '0, "R10 string");
    cyc(0, 8'h00, 16'h0000, 0, 1, Q0, 1, 1, 0, 1, 0, 16'h0171, "R10 R9 step mid");
    cyc(1, 8'hAE, 16'h0200, 0, 0, Q1, 1, 0, 1, 0, 0, '0, "R9 rep cleared");
    chk_cnt(16'd2, "R9 R6");

    // R8/R4: step on last iteration resumes after opcode
    set_count(16'd1);
    cyc(1, 8'hF3, 16'h0180, 0, 0, Q1, 0, 0, 0, 0, 0, '0, "R4 rep");
    cyc(1, 8'hA7, 16'h0181, 0, 0, Q1, 0, 0, 0, 0, 0, '0, "R4 string");
    cyc(0, 8'h00, 16'h0000, 0, 1, Q0, 1, 1, 1, 1, 0, 16'h0182, "R8 last iter step");
    chk_cnt(16'd0, "R4 last");

    // R12: reset clears the repeat bit
    set_count(16'd3);
    cyc(1, 8'hF3, 16'h0190, 0, 0, Q1, 0, 0, 0, 0, 0, '0, "R12 rep");
    @(negedge clk);
    byte_vld = 1'b0;
    #12;
    rst_ni = 1'b0;
    #2;
    rst_ni = 1'b1;
    cyc(1, 8'hA4, 16'h0191, 0, 0, Q1, 1, 0, 1, 0, 0, '0, "R12 rep cleared by reset");
    chk_cnt(16'd3, "R12");
    idle("end");
    @(negedge clk);
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule